// File: doc/BRIEF.md
# DE-Gap Sync Regenerator

This block rebuilds horizontal and vertical sync pulses for a video source that carries only a data-enable qualifier and no sync signals of its own. On each pixel clock it counts how many pixels in a row have had data-enable low. A blanking gap whose length reaches the horizontal threshold marks the end of a line. A gap that keeps going until it reaches the longer vertical threshold marks the end of a frame. From these two events the block produces one-clock sync pulses, so that logic further down can order lines and frames correctly.

Data-enable and pixel data go through one register stage. Each generated pulse therefore leaves the block in the same cycle as the blank pixel that completed the threshold. The two thresholds arrive as plain inputs, and the block checks that they form a usable pair. If they do not, it raises an error flag and produces no syncs. A long gap can fill the counter, and the counter then saturates, so that neither pulse fires a second time in the same gap.

Top module: `degap_sync_regen`

## Requirements
- R1: `de_out` and `data_out` equal the `de_in` and `data_in` values sampled at the previous rising clock edge (one register of delay).
- R2: The gap count is the number of consecutive edges that sampled `de_in` low. A sample with `de_in` high clears it to zero, so a gap broken by a single active pixel starts counting again from one.
- R3: `hsync_out` is high for exactly the cycle in which `de_out` shows the blank pixel whose gap count equals `hgap_len`.
- R4: `vsync_out` is high for exactly the cycle in which `de_out` shows the blank pixel whose gap count equals `vgap_len`.
- R5: Each pulse lasts one cycle and fires at most once per gap. A gap shorter than a threshold produces no pulse for that threshold.
- R6: The threshold pair is valid only when `hgap_len` > 1 and `hgap_len` < `vgap_len`. With an invalid pair, `cfg_err` reads 1 one cycle later and neither sync pulse is emitted. With a valid pair, `cfg_err` reads 0.
- R7: Within one gap that reaches both thresholds, `hsync_out` fires first and `vsync_out` follows `vgap_len` − `hgap_len` cycles later. The two are never high together.
- R8: While `rst_n` is low, `de_out`, `data_out`, `hsync_out`, `vsync_out` and `cfg_err` are all 0.
- R9: The gap count saturates at 2^CNT_W − 1. A gap longer than the counter range does not wrap and does not fire either pulse again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de_in | input | 1 | Incoming data-enable, high for active pixels |
| data_in | input | DATA_W | Incoming pixel data |
| hgap_len | input | CNT_W | Blank-pixel count that ends a line |
| vgap_len | input | CNT_W | Blank-pixel count that ends a frame |
| de_out | output | 1 | Data-enable delayed by one cycle |
| data_out | output | DATA_W | Pixel data delayed by one cycle |
| hsync_out | output | 1 | One-cycle line sync pulse |
| vsync_out | output | 1 | One-cycle frame sync pulse |
| cfg_err | output | 1 | Threshold pair is invalid |

## Verification
The bench builds the block with DATA_W = 8 and CNT_W = 6. The counter then fills after 63 blank pixels, so a 140-pixel gap exercises saturation (R9) and would expose a counter that wraps and fires again. Thresholds are applied at the tightest legal pair (2, 3), at illegal pairs (equal values, a horizontal threshold of 1 or 0) and at a vertical threshold equal to the counter ceiling.

// File: rtl/degap_pkg.sv
package degap_pkg;

  localparam int NUM_SYNC = 2;

  typedef enum int {
    SYNC_LINE  = 0,
    SYNC_FRAME = 1
  } sync_kind_e;

  // Threshold pair is usable: line threshold above one and below frame threshold.
  function automatic logic pair_valid(input logic [31:0] h_thr, input logic [31:0] v_thr);
    return (h_thr > 32'd1) && (h_thr < v_thr);
  endfunction

  // Next gap count: clear on active pixel, otherwise count up and hold at ceiling.
  function automatic logic [31:0] next_gap(input logic [31:0] cur, input logic [31:0] ceiling,
                                           input logic de);
    if (de) return 32'd0;
    if (cur == ceiling) return ceiling;
    return cur + 32'd1;
  endfunction

  // The count advances into the threshold value on this sample.
  function automatic logic reaches(input logic [31:0] cur, input logic [31:0] ceiling,
                                   input logic de, input logic [31:0] thr);
    return !de && (cur != ceiling) && ((cur + 32'd1) == thr);
  endfunction

endpackage

// File: rtl/degap_gap_counter.sv
module degap_gap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_in,
  output logic [CNT_W-1:0] gap_cnt,
  output logic             cnt_advances
);
  localparam logic [CNT_W-1:0] CNT_CEIL = '1;

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt      = CNT_W'(degap_pkg::next_gap(32'(gap_cnt), 32'(CNT_CEIL), de_in));
    cnt_advances = !de_in && (gap_cnt != CNT_CEIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_cnt <= '0;
    else        gap_cnt <= cnt_nxt;
  end
endmodule

// File: rtl/degap_thresh_pulse.sv
module degap_thresh_pulse #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_in,
  input  logic             enable,
  input  logic [CNT_W-1:0] gap_cnt,
  input  logic [CNT_W-1:0] threshold,
  output logic             hit,
  output logic             pulse
);
  localparam logic [CNT_W-1:0] CNT_CEIL = '1;

  always_comb begin
    hit = enable && degap_pkg::reaches(32'(gap_cnt), 32'(CNT_CEIL), de_in, 32'(threshold));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= hit;
  end
endmodule

// File: rtl/degap_cfg_check.sv
module degap_cfg_check #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hgap_len,
  input  logic [CNT_W-1:0] vgap_len,
  output logic             cfg_ok,
  output logic             cfg_err
);
  always_comb begin
    cfg_ok = degap_pkg::pair_valid(32'(hgap_len), 32'(vgap_len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= !cfg_ok;
  end
endmodule

// File: rtl/degap_align.sv
module degap_align #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              de_out,
  output logic [DATA_W-1:0] data_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_out   <= 1'b0;
      data_out <= '0;
    end else begin
      de_out   <= de_in;
      data_out <= data_in;
    end
  end
endmodule

// File: rtl/degap_sync_regen.sv
module degap_sync_regen #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CNT_W-1:0]  hgap_len,
  input  logic [CNT_W-1:0]  vgap_len,
  output logic              de_out,
  output logic [DATA_W-1:0] data_out,
  output logic              hsync_out,
  output logic              vsync_out,
  output logic              cfg_err
);
  import degap_pkg::*;

  // Named internal events, brought out for the checker.
  logic [CNT_W-1:0] gap_cnt;
  logic             cnt_advances;
  logic             cfg_ok;
  logic [CNT_W-1:0] thr   [NUM_SYNC];
  logic             hits  [NUM_SYNC];
  logic             pulses[NUM_SYNC];

  assign thr[SYNC_LINE]  = hgap_len;
  assign thr[SYNC_FRAME] = vgap_len;

  degap_cfg_check #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .hgap_len(hgap_len), .vgap_len(vgap_len),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err)
  );

  degap_gap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .de_in(de_in),
    .gap_cnt(gap_cnt), .cnt_advances(cnt_advances)
  );

  for (genvar k = 0; k < NUM_SYNC; k++) begin : g_sync
    degap_thresh_pulse #(.CNT_W(CNT_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .de_in(de_in), .enable(cfg_ok),
      .gap_cnt(gap_cnt), .threshold(thr[k]),
      .hit(hits[k]), .pulse(pulses[k])
    );
  end

  assign hsync_out = pulses[SYNC_LINE];
  assign vsync_out = pulses[SYNC_FRAME];

  degap_align #(.DATA_W(DATA_W)) u_align (
    .clk(clk), .rst_n(rst_n), .de_in(de_in), .data_in(data_in),
    .de_out(de_out), .data_out(data_out)
  );
endmodule

// File: rtl/degap_sync_regen_sva.sv
module degap_sync_regen_sva #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              de_in,
  input logic [DATA_W-1:0] data_in,
  input logic              de_out,
  input logic [DATA_W-1:0] data_out,
  input logic              hsync_out,
  input logic              vsync_out,
  input logic              cfg_err,
  input logic [CNT_W-1:0]  gap_cnt
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (de_out == $past(de_in)) && (data_out == $past(data_in)));

  assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(de_in) |-> gap_cnt == '0);

  assert_hs_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_out |-> !de_out);

  assert_vs_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_out |-> !de_out);

  assert_hs_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_out |=> !hsync_out);

  assert_vs_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_out |=> !vsync_out);

  assert_cfg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_out || vsync_out) |-> !cfg_err);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hsync_out, vsync_out}) <= 1);

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (gap_cnt == '0) || (gap_cnt >= $past(gap_cnt)));
endmodule

bind degap_sync_regen degap_sync_regen_sva #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .de_in(de_in), .data_in(data_in),
  .de_out(de_out), .data_out(data_out), .hsync_out(hsync_out),
  .vsync_out(vsync_out), .cfg_err(cfg_err), .gap_cnt(gap_cnt)
);

// File: tb/tb_degap_sync_regen.sv
module tb_degap_sync_regen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          de_in = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [CW-1:0] hgap_len = 6'd4;
  logic [CW-1:0] vgap_len = 6'd10;
  logic          de_out, hsync_out, vsync_out, cfg_err;
  logic [DW-1:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  degap_sync_regen #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .de_in(de_in), .data_in(data_in),
    .hgap_len(hgap_len), .vgap_len(vgap_len), .de_out(de_out),
    .data_out(data_out), .hsync_out(hsync_out), .vsync_out(vsync_out),
    .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Apply one pixel, let one edge pass, return just after it.
  task automatic cyc(input logic de, input logic [DW-1:0] d);
    de_in   = de;
    data_in = d;
    @(posedge clk);
    #1;
  endtask

  task automatic active(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, DW'(8'hA0 + i));
  endtask

  // Blank gap of len pixels; expect pulses only at positions eh and ev (0 = never).
  task automatic gap(input string req, input int len, input int eh, input int ev);
    int nh = 0;
    int nv = 0;
    for (int i = 1; i <= len; i++) begin
      cyc(1'b0, DW'(i));
      if (hsync_out !== (i == eh)) begin
        chk(req, $sformatf("hsync at gap pixel %0d", i), int'(hsync_out), int'(i == eh));
      end
      if (vsync_out !== (i == ev)) begin
        chk(req, $sformatf("vsync at gap pixel %0d", i), int'(vsync_out), int'(i == ev));
      end
      nh += int'(hsync_out);
      nv += int'(vsync_out);
    end
    chk(req, "hsync pulses in gap", nh, (eh != 0) ? 1 : 0);
    chk(req, "vsync pulses in gap", nv, (ev != 0) ? 1 : 0);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "de_out in reset", int'(de_out), 0);
    chk("R8", "data_out in reset", int'(data_out), 0);
    chk("R8", "hsync in reset", int'(hsync_out), 0);
    chk("R8", "vsync in reset", int'(vsync_out), 0);
    chk("R8", "cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_passthru;
    logic pat [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 6; i++) begin
      cyc(pat[i], DW'(8'h3C ^ i));
      chk("R1", "de_out delayed", int'(de_out), int'(pat[i]));
      chk("R1", "data_out delayed", int'(data_out), int'(8'h3C ^ i));
    end
  endtask

  task automatic t_line_only;
    hgap_len = 6'd4; vgap_len = 6'd10;
    active(3);
    chk("R6", "cfg_err with 4/10", int'(cfg_err), 0);
    gap("R3", 6, 4, 0);
    active(2);
    gap("R5", 3, 0, 0);
  endtask

  task automatic t_frame;
    active(4);
    gap("R4", 15, 4, 10);
    active(1);
    gap("R7", 10, 4, 10);
    active(1);
  endtask

  task automatic t_restart;
    active(2);
    gap("R2", 3, 0, 0);
    active(1);
    gap("R2", 3, 0, 0);
    active(1);
    gap("R2", 5, 4, 0);
    active(1);
  endtask

  task automatic t_saturate;
    hgap_len = 6'd20; vgap_len = 6'd63;
    active(2);
    gap("R9", 140, 20, 63);
    active(1);
    hgap_len = 6'd4; vgap_len = 6'd10;
  endtask

  task automatic t_badcfg;
    hgap_len = 6'd1; vgap_len = 6'd10;
    active(2);
    chk("R6", "cfg_err with h=1", int'(cfg_err), 1);
    gap("R6", 20, 0, 0);
    hgap_len = 6'd5; vgap_len = 6'd5;
    active(1);
    chk("R6", "cfg_err with h=v", int'(cfg_err), 1);
    gap("R6", 12, 0, 0);
    hgap_len = 6'd0; vgap_len = 6'd10;
    active(1);
    chk("R6", "cfg_err with h=0", int'(cfg_err), 1);
    gap("R6", 12, 0, 0);
    hgap_len = 6'd2; vgap_len = 6'd3;
    active(1);
    chk("R6", "cfg_err with 2/3", int'(cfg_err), 0);
    gap("R7", 5, 2, 3);
    active(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_passthru();
    t_line_only();
    t_frame();
    t_restart();
    t_saturate();
    t_badcfg();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule